// File: doc/BRIEF.md
# Power-Good Shutdown Output Controller

This block generates the active-low shutdown/reset line for a camera module from the state of its supply rails. It takes one power-good flag per regulator, already synchronised to the block clock. It also takes a per-rail mask register, a host force level, the enable-pin level, a sequencer-done flag, and undervoltage and over-temperature fault flags. From these it decides when the module may leave shutdown.

Two modes select how release is qualified. When the enable pin is high, the pin owns the line: the force level has no effect, and release waits for the sequencer to finish and for every unmasked rail to be good. When the pin is low, the host owns the line: the output stays low until the force level is set, and then release follows the unmasked rails.

In both modes the line goes high only after the release condition has held for a fixed number of clock edges. It drops in the same cycle that the condition is lost or a fault appears. A small read-only status word shows the power-good flags at fixed bit positions.

Top module: `rail_release_ctl`

## Requirements
- R1: While reset is asserted and after reset, `xs_n_o` is 0 and the mask register holds `MASK_INIT`. Until it is written, a rail whose `MASK_INIT` bit is 1 does not block release.
- R2: Mask bit k at 1 makes `pgood_i[k]` irrelevant. Mask bit k at 0 requires `pgood_i[k]` = 1 before `xs_n_o` can be 1.
- R3: With `en_pin_i` = 0 and `force_i` = 0, `xs_n_o` is 0 whatever the rail states.
- R4: With `en_pin_i` = 0 and `force_i` = 1, release is governed only by the unmasked power-good flags (and faults).
- R5: With `en_pin_i` = 1, `force_i` is ignored, and release additionally requires `seq_done_i` = 1.
- R6: `uv_fault_i` = 1 or `tsd_fault_i` = 1 forces `xs_n_o` to 0 in the same cycle, without waiting for a clock edge.
- R7: Once the release condition holds, `xs_n_o` rises at the `DELAY_CYC`-th rising clock edge at which it is sampled true, and not earlier.
- R8: If the condition is lost (a required power-good drops, a mode qualifier drops or a fault appears), `xs_n_o` falls in that cycle. The delay then restarts from zero.
- R9: `status_o[3]`, `status_o[2]` and `status_o[1]` show `pgood_i[0]`, `pgood_i[1]` and `pgood_i[2]`. `status_o[0]` shows `force_i`.
- R10: A rising edge with `mask_we_i` = 1 loads `mask_d_i` into the mask register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pgood_i | input | NUM_RAILS | Power-good flag per rail, index 0 = first rail |
| mask_we_i | input | 1 | Mask register write strobe |
| mask_d_i | input | NUM_RAILS | Mask write data, 1 = ignore rail |
| force_i | input | 1 | Host release permission (host mode only) |
| en_pin_i | input | 1 | Enable-pin level, 1 = pin mode |
| seq_done_i | input | 1 | Sequencer finished (pin mode qualifier) |
| uv_fault_i | input | 1 | Undervoltage fault |
| tsd_fault_i | input | 1 | Thermal shutdown fault |
| xs_n_o | output | 1 | Shutdown line, 0 = held in shutdown |
| status_o | output | NUM_RAILS+1 | Power-good status view plus force level |

## Verification
A wrong mask bit shows as the line rising with an ignored rail low, or never rising with a masked rail low. This is visible `DELAY_CYC` edges after the inputs settle. A counter that fails to clear shows as an early rise on the next attempt, before the `DELAY_CYC`-th edge. A lost mode qualifier or fault gate shows in the same cycle as a high line while a fault or a cleared force level is present.

// File: rtl/rail_release_pkg.sv
package rail_release_pkg;
  typedef enum logic {MODE_HOST = 1'b0, MODE_PIN = 1'b1} own_mode_e;

  function automatic logic rails_met(input logic [7:0] pg, input logic [7:0] msk, input int n);
    logic ok;
    ok = 1'b1;
    for (int k = 0; k < n; k++) ok &= (pg[k] | msk[k]);
    return ok;
  endfunction
endpackage

// File: rtl/rr_mask_reg.sv
module rr_mask_reg #(
  parameter int unsigned       NUM_RAILS = 3,
  parameter logic [NUM_RAILS-1:0] MASK_INIT = '0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [NUM_RAILS-1:0] d_i,
  output logic [NUM_RAILS-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= MASK_INIT;
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/rr_gate.sv
module rr_gate
  import rail_release_pkg::*;
#(
  parameter int unsigned NUM_RAILS = 3
) (
  input  logic [NUM_RAILS-1:0] pgood_i,
  input  logic [NUM_RAILS-1:0] mask_i,
  input  logic                 force_i,
  input  logic                 en_pin_i,
  input  logic                 seq_done_i,
  input  logic                 uv_fault_i,
  input  logic                 tsd_fault_i,
  output logic                 arm_o
);
  own_mode_e mode;
  logic      rails_ok, mode_ok, fault;

  always_comb begin
    logic [7:0] pg8, mk8;
    pg8 = '0;
    mk8 = '0;
    pg8[NUM_RAILS-1:0] = pgood_i;
    mk8[NUM_RAILS-1:0] = mask_i;
    rails_ok = rails_met(pg8, mk8, NUM_RAILS);
  end

  assign mode    = en_pin_i ? MODE_PIN : MODE_HOST;
  // pin mode waits for the sequencer, host mode for the force level
  assign mode_ok = (mode == MODE_PIN) ? seq_done_i : force_i;
  assign fault   = uv_fault_i | tsd_fault_i;
  assign arm_o   = rails_ok & mode_ok & ~fault;
endmodule

// File: rtl/rr_release_timer.sv
module rr_release_timer #(
  parameter int unsigned DELAY_CYC = 1000,
  localparam int unsigned CW = (DELAY_CYC < 2) ? 1 : $clog2(DELAY_CYC)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  output logic rel_o
);
  localparam logic [CW-1:0] LAST = CW'(DELAY_CYC - 1);
  logic [CW-1:0] cnt_q;
  logic          rel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rel_q <= 1'b0;
    end else if (!arm_i) begin
      cnt_q <= '0;
      rel_q <= 1'b0;
    end else if (cnt_q == LAST) begin
      rel_q <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // combinational gate gives same-cycle drop on loss of condition
  assign rel_o = rel_q & arm_i;
endmodule

// File: rtl/rail_release_ctl.sv
module rail_release_ctl #(
  parameter int unsigned          NUM_RAILS = 3,
  parameter int unsigned          DELAY_CYC = 1000,
  parameter logic [NUM_RAILS-1:0] MASK_INIT = '0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_RAILS-1:0] pgood_i,
  input  logic                 mask_we_i,
  input  logic [NUM_RAILS-1:0] mask_d_i,
  input  logic                 force_i,
  input  logic                 en_pin_i,
  input  logic                 seq_done_i,
  input  logic                 uv_fault_i,
  input  logic                 tsd_fault_i,
  output logic                 xs_n_o,
  output logic [NUM_RAILS:0]   status_o
);
  logic [NUM_RAILS-1:0] mask_q;
  logic                 arm;

  rr_mask_reg #(.NUM_RAILS(NUM_RAILS), .MASK_INIT(MASK_INIT)) u_mask (
    .clk_i (clk_i), .rst_ni(rst_ni), .we_i(mask_we_i), .d_i(mask_d_i), .q_o(mask_q)
  );

  rr_gate #(.NUM_RAILS(NUM_RAILS)) u_gate (
    .pgood_i(pgood_i), .mask_i(mask_q), .force_i(force_i), .en_pin_i(en_pin_i),
    .seq_done_i(seq_done_i), .uv_fault_i(uv_fault_i), .tsd_fault_i(tsd_fault_i),
    .arm_o(arm)
  );

  rr_release_timer #(.DELAY_CYC(DELAY_CYC)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .arm_i(arm), .rel_o(xs_n_o)
  );

  // first rail at the top status bit, descending
  for (genvar k = 0; k < NUM_RAILS; k++) begin : g_stat
    assign status_o[NUM_RAILS-k] = pgood_i[k];
  end
  assign status_o[0] = force_i;
endmodule

// File: rtl/rail_release_ctl_chk.sv
module rail_release_ctl_chk #(
  parameter int unsigned NUM_RAILS = 3,
  parameter int unsigned DELAY_CYC = 1000
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [NUM_RAILS-1:0] pgood_i,
  input logic [NUM_RAILS-1:0] mask_q,
  input logic                 force_i,
  input logic                 en_pin_i,
  input logic                 seq_done_i,
  input logic                 uv_fault_i,
  input logic                 tsd_fault_i,
  input logic                 xs_n_o
);
  localparam int unsigned RW = $clog2(DELAY_CYC + 1) + 1;
  logic [RW-1:0] run_q;
  logic          cond;

  assign cond = (&(pgood_i | mask_q)) & (en_pin_i ? seq_done_i : force_i)
              & ~uv_fault_i & ~tsd_fault_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   run_q <= '0;
    else if (!cond)                run_q <= '0;
    else if (run_q < RW'(DELAY_CYC)) run_q <= run_q + 1'b1;
  end

  // R3
  host_hold_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_pin_i && !force_i) |-> !xs_n_o);
  // R6
  fault_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uv_fault_i || tsd_fault_i) |-> !xs_n_o);
  // R2
  masked_pg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xs_n_o |-> &(pgood_i | mask_q));
  // R5
  pin_seq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_pin_i && !seq_done_i) |-> !xs_n_o);
  // R7
  delay_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(xs_n_o) |-> (run_q >= RW'(DELAY_CYC)));
endmodule

bind rail_release_ctl rail_release_ctl_chk #(.NUM_RAILS(NUM_RAILS), .DELAY_CYC(DELAY_CYC)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pgood_i(pgood_i), .mask_q(mask_q), .force_i(force_i),
  .en_pin_i(en_pin_i), .seq_done_i(seq_done_i), .uv_fault_i(uv_fault_i),
  .tsd_fault_i(tsd_fault_i), .xs_n_o(xs_n_o)
);

// File: tb/rail_release_ctl_test.sv
module rail_release_ctl_test;
  localparam int D = 4;
  localparam logic [2:0] MINIT = 3'b010;

  logic       clk = 0, rst_ni = 0;
  logic [2:0] pgood = 0, mask_d = 0;
  logic       mask_we = 0, force_b = 0, en_pin = 0, seq_done = 0, uv = 0, tsd = 0;
  logic       xs;
  logic [3:0] status;
  int total = 0, bad = 0;
  bit done = 0;

  rail_release_ctl #(.NUM_RAILS(3), .DELAY_CYC(D), .MASK_INIT(MINIT)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .pgood_i(pgood), .mask_we_i(mask_we), .mask_d_i(mask_d),
    .force_i(force_b), .en_pin_i(en_pin), .seq_done_i(seq_done), .uv_fault_i(uv),
    .tsd_fault_i(tsd), .xs_n_o(xs), .status_o(status)
  );

  always #5 clk = ~clk;

  task automatic check(input logic [3:0] act, input logic [3:0] exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic idle_and_mask(input logic [2:0] m);
    @(negedge clk);
    pgood = 0; force_b = 0; en_pin = 0; seq_done = 0; uv = 0; tsd = 0;
    mask_we = 1; mask_d = m;
    @(negedge clk);
    mask_we = 0;
  endtask

  task automatic wait_edges(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1 reset state
    #22;
    check({3'b0, xs}, 4'b0, "R1 low in reset");
    @(negedge clk); rst_ni = 1;
    // R1 default mask: rail index 1 ignored
    @(negedge clk); pgood = 3'b101; force_b = 1;
    wait_edges(D - 1); check({3'b0, xs}, 4'b0, "R1 not early");
    wait_edges(1);     check({3'b0, xs}, 4'b1, "R1 default mask");

    // sweep: R2 R3 R4 R5 R6 R7 R9 R10
    for (int m = 0; m < 8; m++)
      for (int p = 0; p < 8; p++)
        for (int e = 0; e < 2; e++)
          for (int f = 0; f < 2; f++)
            for (int s = 0; s < 2; s++)
              for (int fl = 0; fl < 3; fl++) begin
                logic ex;
                idle_and_mask(3'(m));
                pgood = 3'(p); en_pin = e[0]; force_b = f[0]; seq_done = s[0];
                uv = (fl == 1); tsd = (fl == 2);
                ex = (&(3'(p) | 3'(m))) & (e[0] ? s[0] : f[0]) & (fl == 0);
                #1 check(status, {pgood[0], pgood[1], pgood[2], force_b}, "R9 status");
                wait_edges(D - 1);
                check({3'b0, xs}, 4'b0, "R7 no early release");
                wait_edges(1);
                check({3'b0, xs}, {3'b0, ex},
                      e ? "R5 pin mode" : (f ? "R4 host force R2 R10 R6" : "R3 host hold"));
              end

    // R6 same-cycle fault drop and restart
    idle_and_mask(3'b000);
    pgood = 3'b111; force_b = 1;
    wait_edges(D); check({3'b0, xs}, 4'b1, "R6 pre-release");
    @(negedge clk); tsd = 1; #1 check({3'b0, xs}, 4'b0, "R6 immediate drop");
    @(negedge clk); tsd = 0;
    wait_edges(D - 1); check({3'b0, xs}, 4'b0, "R6 restart not early");
    wait_edges(1);     check({3'b0, xs}, 4'b1, "R6 restart release");

    // R8 required rail drop mid-count restarts delay
    idle_and_mask(3'b000);
    pgood = 3'b111; en_pin = 1; seq_done = 1;
    wait_edges(D - 1);
    @(negedge clk); pgood = 3'b011; #1 check({3'b0, xs}, 4'b0, "R8 drop");
    @(negedge clk); pgood = 3'b111;
    wait_edges(D - 1); check({3'b0, xs}, 4'b0, "R8 counter restarted");
    wait_edges(1);     check({3'b0, xs}, 4'b1, "R8 release after restart");
    @(negedge clk); pgood = 3'b110; #1 check({3'b0, xs}, 4'b0, "R8 drop after release");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule